// File: doc/BRIEF.md
# Reconfigurable Segment-Insertion Scan Network

This block is a small on-chip scan network that sits behind a test-access gateway, which a JTAG TAP controller normally drives. Its chain is built from a row of segment-insertion cells. Each cell can splice a hosted segment into the live scan path or leave it out. Every hosted segment is a short test data register for one self-test instrument. The register's update stage drives the instrument's run and reset controls, and its shift stage captures the instrument's done and fail results.

The length of the chain is not fixed. A tester first scans a pattern through the cells. When the gateway then issues an update, each cell's configuration latch decides whether its segment joins the path on the next scan. A closed cell acts as a one-bit bypass. While its segment is cut off, the instrument behind it keeps the controls it was last given, so it can go on running. The gateway signals are serial in, select, capture enable, shift enable, update enable, an active-low reset and the test clock. The block returns serial out.

Top module: `sibScanNet`

## Requirements
- R1: While `rstN` is low, every cell configuration latch and every instrument control latch is 0, `instRun` and `instRst` are all 0, and `so` is 0. After reset the path is `NUM_SIB` bits long, one bit per cell.
- R2: The path is `NUM_SIB + TDR_W * (number of open cells)` bits long. Counting from `so`, it holds cell `NUM_SIB-1` first. If that cell is open, its segment bits 0 to `TDR_W-1` come next, then the next lower cell, and so on down to cell 0, which is nearest `si`. A closed cell is a single bypass bit.
- R3: On a rising `tck` edge with `sel` and `captureEn` high, each cell's shift bit loads that cell's configuration latch (1 = open). Each open segment loads done into bit 0 and fail into bit 1.
- R4: On a falling `tck` edge with `sel` and `updateEn` high, each cell's configuration latch loads its shift bit. Each segment that was open before that edge loads its shift bits into its controls: bit 0 drives `instRun` and bit 1 drives `instRst`.
- R5: A segment that is closed does not change its controls, whatever update or scan activity takes place.
- R6: With `sel` low, capture, shift and update have no effect on any latch, control or shift bit.
- R7: `so` changes only after a rising edge on which `sel` is high together with `shiftEn` or `captureEn`, or under reset.
- R8: A new path length takes effect only after the update edge. The scan that carries the new configuration still uses the old length.
- R9: When `captureEn` and `shiftEn` are both high, capture takes priority and no shift happens on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Active-low asynchronous reset |
| si | input | 1 | Serial data from the gateway |
| sel | input | 1 | Gateway select for this network |
| captureEn | input | 1 | Capture enable |
| shiftEn | input | 1 | Shift enable |
| updateEn | input | 1 | Update enable |
| so | output | 1 | Serial data back to the gateway |
| instDone | input | NUM_SIB | Done status from each instrument |
| instFail | input | NUM_SIB | Fail status from each instrument |
| instRun | output | NUM_SIB | Run control to each instrument |
| instRst | output | NUM_SIB | Reset control to each instrument |

## Verification
The bench walks through every transition from one open-cell pattern to another. In each case the scan that programs the new pattern has to run at the old length. A design that switched the length early would misplace every later bit and return garbage at `so`.

Each scan also checks that the first bit shifted in comes out exactly one path length later. This catches a closed cell that is not a clean single-bit bypass, as well as any reversed bit order inside a segment.

Controls of closed segments are compared after every update. A design that let update reach a cut-off register would overwrite an instrument that should keep running. Scans with `sel` low and capture edges with shift also asserted cover the gating and priority rules.

// File: rtl/sibNetPkg.sv
package sibNetPkg;
  // Gated gateway strobes delivered from control to the datapath.
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } scanStrobeT;
endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import sibNetPkg::*;
#(
  parameter int NUM_SIB = 3
) (
  input  logic               sel,
  input  logic               captureEn,
  input  logic               shiftEn,
  input  logic               updateEn,
  input  logic [NUM_SIB-1:0] sibOpen,
  output scanStrobeT         gwStb,
  output scanStrobeT         segStb [NUM_SIB]
);
  // Capture has priority over shift on the same edge.
  always_comb begin
    gwStb.capture = sel & captureEn;
    gwStb.shift   = sel & shiftEn & ~captureEn;
    gwStb.update  = sel & updateEn;
  end

  // A hosted segment only sees strobes while its cell is open.
  for (genvar i = 0; i < NUM_SIB; i++) begin : g_seg
    always_comb begin
      segStb[i].capture = gwStb.capture & sibOpen[i];
      segStb[i].shift   = gwStb.shift   & sibOpen[i];
      segStb[i].update  = gwStb.update  & sibOpen[i];
    end
  end
endmodule

// File: rtl/sibCell.sv
module sibCell
  import sibNetPkg::*;
(
  input  logic       tck,
  input  logic       rstN,
  input  scanStrobeT stb,
  input  logic       sibIn,
  input  logic       segRet,
  output logic       sibOut,
  output logic       open
);
  logic shiftBit;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)            shiftBit <= 1'b0;
    else if (stb.capture) shiftBit <= open;
    else if (stb.shift)   shiftBit <= open ? segRet : sibIn;
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN)           open <= 1'b0;
    else if (stb.update) open <= shiftBit;
  end

  assign sibOut = shiftBit;
endmodule

// File: rtl/instrTdr.sv
module instrTdr
  import sibNetPkg::*;
#(
  parameter int TDR_W = 2
) (
  input  logic             tck,
  input  logic             rstN,
  input  scanStrobeT       stb,
  input  logic             segIn,
  input  logic [TDR_W-1:0] statusIn,
  output logic             segOut,
  output logic [TDR_W-1:0] ctrlOut
);
  logic [TDR_W-1:0] shiftReg;

  // Serial data enters at the top bit and leaves from bit 0.
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (stb.capture) shiftReg <= statusIn;
    else if (stb.shift)   shiftReg <= {segIn, shiftReg[TDR_W-1:1]};
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN)           ctrlOut <= '0;
    else if (stb.update) ctrlOut <= shiftReg;
  end

  assign segOut = shiftReg[0];
endmodule

// File: rtl/scanDatapath.sv
module scanDatapath
  import sibNetPkg::*;
#(
  parameter int NUM_SIB = 3,
  parameter int TDR_W   = 2,
  localparam int BUS_W  = NUM_SIB * TDR_W
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               si,
  input  scanStrobeT         gwStb,
  input  scanStrobeT         segStb [NUM_SIB],
  input  logic [BUS_W-1:0]   statusBus,
  output logic [BUS_W-1:0]   ctrlBus,
  output logic [NUM_SIB-1:0] sibOpen,
  output logic               so
);
  logic [NUM_SIB:0]   link;
  logic [NUM_SIB-1:0] segRet;

  assign link[0] = si;

  for (genvar i = 0; i < NUM_SIB; i++) begin : g_cell
    instrTdr #(.TDR_W(TDR_W)) uTdr (
      .tck      (tck),
      .rstN     (rstN),
      .stb      (segStb[i]),
      .segIn    (link[i]),
      .statusIn (statusBus[i*TDR_W +: TDR_W]),
      .segOut   (segRet[i]),
      .ctrlOut  (ctrlBus[i*TDR_W +: TDR_W])
    );
    sibCell uSib (
      .tck    (tck),
      .rstN   (rstN),
      .stb    (gwStb),
      .sibIn  (link[i]),
      .segRet (segRet[i]),
      .sibOut (link[i+1]),
      .open   (sibOpen[i])
    );
  end

  assign so = link[NUM_SIB];
endmodule

// File: rtl/sibScanNet.sv
module sibScanNet
  import sibNetPkg::*;
#(
  parameter int NUM_SIB = 3
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               si,
  input  logic               sel,
  input  logic               captureEn,
  input  logic               shiftEn,
  input  logic               updateEn,
  output logic               so,
  input  logic [NUM_SIB-1:0] instDone,
  input  logic [NUM_SIB-1:0] instFail,
  output logic [NUM_SIB-1:0] instRun,
  output logic [NUM_SIB-1:0] instRst
);
  localparam int TDR_W = 2;
  localparam int BUS_W = NUM_SIB * TDR_W;

  scanStrobeT         gwStb;
  scanStrobeT         segStb [NUM_SIB];
  logic [NUM_SIB-1:0] sibOpen;
  logic [BUS_W-1:0]   statusBus;
  logic [BUS_W-1:0]   ctrlBus;

  for (genvar i = 0; i < NUM_SIB; i++) begin : g_map
    assign statusBus[i*TDR_W]     = instDone[i];
    assign statusBus[i*TDR_W + 1] = instFail[i];
    assign instRun[i]             = ctrlBus[i*TDR_W];
    assign instRst[i]             = ctrlBus[i*TDR_W + 1];
  end

  scanCtrl #(.NUM_SIB(NUM_SIB)) uCtrl (
    .sel       (sel),
    .captureEn (captureEn),
    .shiftEn   (shiftEn),
    .updateEn  (updateEn),
    .sibOpen   (sibOpen),
    .gwStb     (gwStb),
    .segStb    (segStb)
  );

  scanDatapath #(.NUM_SIB(NUM_SIB), .TDR_W(TDR_W)) uPath (
    .tck       (tck),
    .rstN      (rstN),
    .si        (si),
    .gwStb     (gwStb),
    .segStb    (segStb),
    .statusBus (statusBus),
    .ctrlBus   (ctrlBus),
    .sibOpen   (sibOpen),
    .so        (so)
  );
endmodule

// File: rtl/sibScanNetChk.sv
module sibScanNetChk #(
  parameter int NUM_SIB = 3
) (
  input logic               tck,
  input logic               rstN,
  input logic               sel,
  input logic               captureEn,
  input logic               shiftEn,
  input logic               updateEn,
  input logic               so,
  input logic [NUM_SIB-1:0] sibOpen,
  input logic [NUM_SIB-1:0] instRun,
  input logic [NUM_SIB-1:0] instRst
);
  // R1
  reset_clear_chk: assert property (@(posedge tck)
    !rstN |-> (sibOpen == '0 && instRun == '0 && instRst == '0 && so == 1'b0));

  // R6
  no_update_chk: assert property (@(negedge tck) disable iff (!rstN)
    !(sel && updateEn) |=> ($stable(sibOpen) && $stable(instRun) && $stable(instRst)));

  // R7
  so_hold_chk: assert property (@(negedge tck) disable iff (!rstN)
    !(sel && (shiftEn || captureEn)) |=> $stable(so));

  // R5
  closed_run_hold_chk: assert property (@(posedge tck) disable iff (!rstN)
    ((instRun ^ $past(instRun)) & ~sibOpen & ~$past(sibOpen)) == '0);

  // R5
  closed_rst_hold_chk: assert property (@(posedge tck) disable iff (!rstN)
    ((instRst ^ $past(instRst)) & ~sibOpen & ~$past(sibOpen)) == '0);
endmodule

bind sibScanNet sibScanNetChk #(.NUM_SIB(NUM_SIB)) uChk (
  .tck       (tck),
  .rstN      (rstN),
  .sel       (sel),
  .captureEn (captureEn),
  .shiftEn   (shiftEn),
  .updateEn  (updateEn),
  .so        (so),
  .sibOpen   (sibOpen),
  .instRun   (instRun),
  .instRst   (instRst)
);

// File: tb/tb_sibScanNet.sv
module tb_sibScanNet;
  localparam int N = 3;

  logic tck = 1'b0;
  logic rstN, si, sel, captureEn, shiftEn, updateEn, so;
  logic [N-1:0] instDone, instFail, instRun, instRst;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [N-1:0] mOpen, mRun, mRst;

  always #2 tck = ~tck;

  sibScanNet #(.NUM_SIB(N)) dut (
    .tck(tck), .rstN(rstN), .si(si), .sel(sel), .captureEn(captureEn),
    .shiftEn(shiftEn), .updateEn(updateEn), .so(so),
    .instDone(instDone), .instFail(instFail), .instRun(instRun), .instRst(instRst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkOuts(input string req);
    chk({req, " run"}, 8'(instRun), 8'(mRun));
    chk({req, " rst"}, 8'(instRst), 8'(mRst));
  endtask

  // One full capture/shift/update pass. Inputs change 1 ns after a rising edge.
  task automatic doScan(input logic [N-1:0] nOpen, input logic [N-1:0] nRun,
                        input logic [N-1:0] nRst, input bit useSel);
    logic cap [32];
    logic ld  [32];
    int len = 0;
    logic soBefore;
    for (int i = N - 1; i >= 0; i--) begin
      cap[len] = mOpen[i]; ld[len] = nOpen[i]; len++;
      if (mOpen[i]) begin
        cap[len] = instDone[i]; ld[len] = nRun[i]; len++;
        cap[len] = instFail[i]; ld[len] = nRst[i]; len++;
      end
    end
    soBefore = so;
    sel = useSel; captureEn = 1'b1; shiftEn = 1'b1;   // R9: capture wins over shift
    @(posedge tck); #1;
    captureEn = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (useSel) chk($sformatf("R3/R9 capture pos %0d", k), 8'(so), 8'(cap[k]));
      else        chk("R6 so idle", 8'(so), 8'(soBefore));
      si = ld[k];
      @(posedge tck); #1;
    end
    shiftEn = 1'b0;
    // R2/R8: first bit in reaches so exactly one old path length later
    if (useSel) chk("R2/R8 path length", 8'(so), 8'(ld[0]));
    else        chk("R6 so idle", 8'(so), 8'(soBefore));
    updateEn = 1'b1;
    @(posedge tck); #1;
    updateEn = 1'b0; sel = 1'b0;
    if (useSel) begin
      for (int i = 0; i < N; i++)
        if (mOpen[i]) begin mRun[i] = nRun[i]; mRst[i] = nRst[i]; end  // R4, R5
      mOpen = nOpen;
    end
    chkOuts(useSel ? "R4/R5 controls" : "R6 controls");
  endtask

  initial begin
    rstN = 1'b0; si = 1'b0; sel = 1'b0; captureEn = 1'b0; shiftEn = 1'b0; updateEn = 1'b0;
    instDone = '0; instFail = '0;
    mOpen = '0; mRun = '0; mRst = '0;
    repeat (3) @(posedge tck);
    #1;
    chk("R1 reset so", 8'(so), 8'h0);
    chkOuts("R1 reset");
    rstN = 1'b1;
    @(posedge tck); #1;

    // R2/R8: exhaustive transitions between open-cell patterns
    for (int f = 0; f < (1 << N); f++) begin
      for (int t = 0; t < (1 << N); t++) begin
        instDone = N'(f * 5 + t);
        instFail = N'(t * 3 + f + 1);
        doScan(N'(f), N'(f + t), N'(f ^ (t + 2)), 1'b1);
        instDone = N'(t * 7 + 1);
        instFail = N'(f ^ t);
        doScan(N'(t), N'(t * 3 + f), N'(~(f + t)), 1'b1);
      end
    end

    // R6: scans with select low change nothing
    doScan(N'(5), N'(2), N'(1), 1'b1);
    for (int r = 0; r < 4; r++) doScan(N'(~r), N'(r), N'(r + 3), 1'b0);
    doScan(N'(0), N'(7), N'(7), 1'b1);  // reads back through capture what R6 left alone

    // R1: reset in mid-run clears everything; path returns to N bits
    rstN = 1'b0;
    @(posedge tck); #1;
    mOpen = '0; mRun = '0; mRst = '0;
    chk("R1 mid reset so", 8'(so), 8'h0);
    chkOuts("R1 mid reset");
    rstN = 1'b1;
    @(posedge tck); #1;
    doScan(N'(7), N'(3), N'(4), 1'b1);
    doScan(N'(2), N'(1), N'(6), 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule